// File: doc/BRIEF.md
# Configurable Asynchronous Character Transmitter

This block turns one byte into an asynchronous serial frame on a single transmit line. Software, or a register block next to it, drops a byte into a one-deep holding register with a load strobe. When the transmitter is enabled, the byte moves into a shift register and is sent as a frame. The frame is a low start bit, then 5 to 8 data bits with the least significant bit first. An optional parity bit follows, and the frame ends with a high stop period of one, one and a half or two bit times. The character length, parity, stop length and bit-clock mode come in as decoded configuration fields. They are kept apart from any receiver settings.

Time advances only on a transmit-clock enable tick supplied from outside. In one-clock mode each bit lasts one tick. In sixteen-clock mode each bit lasts sixteen ticks, which also allows a true 1.5-bit stop period. The holding register is freed the moment its byte enters the shift register, so the next byte can be written while the current frame is still on the line. Frames then follow each other with no idle gap.

Top module: `char_tx`

## Requirements
- R1: After reset, `tx_line` is high and `buf_empty` is 1.
- R2: The line idles high. A frame begins with one low start bit, and the line returns high when the frame ends and no byte is waiting.
- R3: `cfg_len` sets the character length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 data bits. Data bits are sent least significant first, and holding-byte bits above the length are not sent.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. If `cfg_par_even` is 1 the bit makes the count of ones even, and if it is 0 the count is odd. Only the configured data bits are counted. When `cfg_par_en` is 0, no parity bit is sent.
- R5: `cfg_clk` = 00 gives one tick per bit. Any other code gives sixteen ticks per bit.
- R6: `cfg_stop` sets the stop period. 01 = one bit. 10 = one and a half bits, which is 24 ticks in sixteen-clock mode and 2 ticks in one-clock mode. 11 = two bits. 00 is treated as one bit.
- R7: `buf_empty` falls the cycle after a load strobe. It rises in the same cycle that the start bit appears on the line.
- R8: If a byte is waiting when a stop period ends, its start bit follows on the very next cycle.
- R9: While `cfg_tx_en` is 0, no frame starts and a loaded byte is kept, with `buf_empty` at 0. Raising `cfg_tx_en` starts that byte's frame on the next cycle.
- R10: A load while the holding register is full replaces the waiting byte.
- R11: A frame advances only on cycles with `tick_en` high. Without ticks, the line holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Transmit-clock enable tick |
| hold_data | input | DATA_W | Byte for the holding register |
| hold_load | input | 1 | Load strobe for the holding register |
| cfg_tx_en | input | 1 | Transmitter enable |
| cfg_len | input | 2 | Character length code |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop | input | 2 | Stop period code |
| cfg_clk | input | 2 | Bit clock mode code |
| tx_line | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding register free |

## Verification
A bad bit counter or a bad tick counter shows up as a level on the line at the wrong time. The fault is visible within one bit period, so the bench compares every cycle of every bit against a waveform it computes from the configuration. A stop period that is too short or too long is caught by chaining a second frame behind the first: the next start edge must land on exactly one cycle. A holding register that frees too early or too late shows up on `buf_empty` in the same cycle as the start bit.

// File: rtl/char_tx_pkg.sv
package char_tx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_phase_e;

  // Number of data bits for a length code; the shortest length is max_bits-3.
  function automatic int unsigned char_bits(input logic [1:0] code,
                                            input int unsigned max_bits);
    return max_bits - 3 + int'(code);
  endfunction

  // Ticks per data-type bit (start, data, parity).
  function automatic int unsigned data_ticks(input logic [1:0] mode,
                                             input int unsigned ovs);
    return (mode == 2'b00) ? 1 : ovs;
  endfunction

  // Ticks for the stop period.
  function automatic int unsigned stop_ticks(input logic [1:0] code,
                                             input logic [1:0] mode,
                                             input int unsigned ovs);
    if (mode == 2'b00) return code[1] ? 2 : 1;
    case (code)
      2'b10:   return ovs + ovs / 2;
      2'b11:   return 2 * ovs;
      default: return ovs;
    endcase
  endfunction

  // Parity bit over the low nbits of data; even = 1 makes the total count even.
  function automatic logic char_parity(input logic [15:0] data,
                                       input int unsigned nbits,
                                       input logic even);
    logic p;
    p = 1'b0;
    for (int unsigned i = 0; i < 16; i++)
      if (i < nbits) p = p ^ data[i];
    return even ? p : ~p;
  endfunction

endpackage

// File: rtl/char_tx_hold.sv
module char_tx_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         take,
  output logic [W-1:0] dout,
  output logic         full
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (load) begin
      full <= 1'b1;
      dout <= din;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  assert_load_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> full);
  assert_take_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load) |=> !full);
  assert_take_needs_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);
  assert_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (dout == $past(din)));

endmodule

// File: rtl/char_tx_pace.sv
module char_tx_pace #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             bit_done
);

  logic [CNT_W-1:0] cnt;

  assign bit_done = run && tick_en && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick_en) cnt <= bit_done ? '0 : cnt + 1'b1;
  end

  assert_no_tick_no_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |-> !bit_done);
  assert_cnt_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit));
  assert_cnt_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick_en) |=> $stable(cnt));

endmodule

// File: rtl/char_tx_seq.sv
module char_tx_seq
  import char_tx_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned OVS   = 16,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             full,
  input  logic [W-1:0]     hold_byte,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_even,
  input  logic [1:0]       cfg_stop,
  input  logic [1:0]       cfg_clk,
  input  logic             bit_done,
  output logic             take,
  output logic             busy,
  output logic             tx_line,
  output logic [CNT_W-1:0] limit
);

  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;

  tx_phase_e      state;
  logic [W-1:0]   shreg;
  logic           par_bit;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;
  logic           start_ok;
  logic           stop_end;
  logic           bit_last;

  always_comb begin
    last_idx = IDX_W'(char_bits(cfg_len, W) - 1);
    start_ok = tx_en && full;
    stop_end = (state == TX_STOP) && bit_done;
    take     = start_ok && ((state == TX_IDLE) || stop_end);
    busy     = (state != TX_IDLE);
    bit_last = (idx == last_idx);
    limit    = (state == TX_STOP) ? CNT_W'(stop_ticks(cfg_stop, cfg_clk, OVS))
                                  : CNT_W'(data_ticks(cfg_clk, OVS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      shreg   <= '0;
      par_bit <= 1'b0;
      idx     <= '0;
      tx_line <= 1'b1;
    end else if (take) begin
      state   <= TX_START;
      shreg   <= hold_byte;
      par_bit <= char_parity(16'(hold_byte), char_bits(cfg_len, W), cfg_par_even);
      idx     <= '0;
      tx_line <= 1'b0;
    end else if (bit_done) begin
      case (state)
        TX_START: begin
          state   <= TX_DATA;
          tx_line <= shreg[0];
          shreg   <= shreg >> 1;
          idx     <= '0;
        end
        TX_DATA: begin
          if (bit_last) begin
            if (cfg_par_en) begin
              state   <= TX_PAR;
              tx_line <= par_bit;
            end else begin
              state   <= TX_STOP;
              tx_line <= 1'b1;
            end
          end else begin
            idx     <= idx + 1'b1;
            tx_line <= shreg[0];
            shreg   <= shreg >> 1;
          end
        end
        TX_PAR: begin
          state   <= TX_STOP;
          tx_line <= 1'b1;
        end
        TX_STOP: begin
          state   <= TX_IDLE;
          tx_line <= 1'b1;
        end
        default: begin
          state   <= TX_IDLE;
          tx_line <= 1'b1;
        end
      endcase
    end
  end

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_IDLE) |-> tx_line);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_START) |-> !tx_line);
  assert_stop_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_STOP) |-> tx_line);
  assert_idx_in_char_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_DATA) |-> (idx <= last_idx));
  assert_disabled_stays_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_IDLE && !tx_en) |=> (state == TX_IDLE));
  assert_no_step_holds_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state != TX_IDLE && !bit_done && !take) |=> ($stable(tx_line) && $stable(state)));
  assert_chain_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_end && start_ok) |=> (state == TX_START));

endmodule

// File: rtl/char_tx.sv
module char_tx
  import char_tx_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_load,
  input  logic              cfg_tx_en,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic [1:0]        cfg_stop,
  input  logic [1:0]        cfg_clk,
  output logic              tx_line,
  output logic              buf_empty
);

  localparam int unsigned CNT_W = $clog2(2 * OVERSAMPLE + 1);

  logic [DATA_W-1:0] held_byte;
  logic              held_full;
  logic              byte_taken;
  logic              frame_busy;
  logic              bit_done;
  logic [CNT_W-1:0]  bit_limit;

  char_tx_hold #(.W(DATA_W)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (hold_load),
    .din  (hold_data),
    .take (byte_taken),
    .dout (held_byte),
    .full (held_full)
  );

  char_tx_pace #(.CNT_W(CNT_W)) u_pace (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .run     (frame_busy),
    .limit   (bit_limit),
    .bit_done(bit_done)
  );

  char_tx_seq #(.W(DATA_W), .OVS(OVERSAMPLE), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (cfg_tx_en),
    .full        (held_full),
    .hold_byte   (held_byte),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_even(cfg_par_even),
    .cfg_stop    (cfg_stop),
    .cfg_clk     (cfg_clk),
    .bit_done    (bit_done),
    .take        (byte_taken),
    .busy        (frame_busy),
    .tx_line     (tx_line),
    .limit       (bit_limit)
  );

  assign buf_empty = !held_full;

  assert_empty_with_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_taken && !hold_load) |=> (buf_empty && !tx_line));

endmodule

// File: tb/char_tx_bench.sv
`timescale 1ns/1ps
module char_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic [7:0] hold_data = '0;
  logic       hold_load = 1'b0;
  logic       c_en = 1'b1;
  logic [1:0] c_len = 2'b11;
  logic       c_pen = 1'b0;
  logic       c_even = 1'b0;
  logic [1:0] c_stop = 2'b01;
  logic [1:0] c_clk = 2'b00;
  logic       tx_line;
  logic       buf_empty;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  char_tx u_char_tx (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .hold_data(hold_data), .hold_load(hold_load),
    .cfg_tx_en(c_en), .cfg_len(c_len), .cfg_par_en(c_pen),
    .cfg_par_even(c_even), .cfg_stop(c_stop), .cfg_clk(c_clk),
    .tx_line(tx_line), .buf_empty(buf_empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Load one byte; returns on the negedge after the strobe, where buf_empty must be 0 (R7).
  task automatic drive_load(input logic [7:0] b);
    @(negedge clk);
    hold_data = b;
    hold_load = 1'b1;
    @(negedge clk);
    hold_load = 1'b0;
    chk(buf_empty == 1'b0, "R7 empty falls after load", buf_empty, 0);
  endtask

  // Called at the negedge showing the first cycle of the start bit.
  task automatic run_frame(input logic [7:0] b, input bit chain, input logic [7:0] nxt);
    int lv[13];
    int du[13];
    string tg[13];
    int n;
    int nb;
    int dt;
    int st;
    logic [7:0] m;
    n  = 0;
    nb = 5 + int'(c_len);
    dt = (c_clk == 2'b00) ? 1 : 16;
    if (c_clk == 2'b00) st = (c_stop >= 2) ? 2 : 1;
    else st = (c_stop == 2'b10) ? 24 : (c_stop == 2'b11) ? 32 : 16;
    lv[n] = 0; du[n] = dt; tg[n] = "R2 start bit"; n++;
    for (int i = 0; i < nb; i++) begin
      lv[n] = int'(b[i]); du[n] = dt; tg[n] = "R3 data bit"; n++;
    end
    if (c_pen) begin
      m = b & 8'((1 << nb) - 1);
      lv[n] = c_even ? int'(^m) : int'(~^m); du[n] = dt; tg[n] = "R4 parity bit"; n++;
    end
    lv[n] = 1; du[n] = st; tg[n] = "R6 stop period"; n++;
    chk(buf_empty == 1'b1, "R7 empty with start bit", buf_empty, 1);
    for (int j = 0; j < n; j++) begin
      bit ok;
      int bad;
      ok = 1;
      bad = lv[j];
      for (int k = 0; k < du[j]; k++) begin
        if (int'(tx_line) != lv[j]) begin ok = 0; bad = int'(tx_line); end
        if (chain && j == 0 && k == 0) begin hold_data = nxt; hold_load = 1'b1; end
        @(negedge clk);
        hold_load = 1'b0;
      end
      chk(ok, tg[j], bad, lv[j]);
    end
    if (chain) chk(tx_line == 1'b0, "R8 next start follows stop", tx_line, 0);
    else begin
      chk(tx_line == 1'b1, "R2 idle high after frame", tx_line, 1);
      chk(buf_empty == 1'b1, "R7 empty when idle", buf_empty, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_line == 1'b1, "R1 reset line", tx_line, 1);
    chk(buf_empty == 1'b1, "R1 reset empty", buf_empty, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_line == 1'b1, "R1 line after reset", tx_line, 1);

    // Sweep of length, parity, stop and clock mode (R3 R4 R5 R6 R8)
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s < 4; s++)
          for (int c = 0; c < 2; c++) begin
            logic [7:0] a;
            logic [7:0] bb;
            int idx;
            idx = ((l * 3 + p) * 4 + s) * 2 + c;
            a  = 8'(37 * idx + 11);
            bb = ~a ^ 8'(idx);
            c_len = 2'(l); c_pen = (p != 0); c_even = (p == 2);
            c_stop = 2'(s); c_clk = c ? 2'b01 : 2'b00;
            drive_load(a);
            @(negedge clk);
            run_frame(a, 1, bb);
            run_frame(bb, 0, 8'h00);
          end

    // Clock code 10 behaves as sixteen ticks per bit (R5)
    c_len = 2'b11; c_pen = 1'b1; c_even = 1'b1; c_stop = 2'b10; c_clk = 2'b10;
    drive_load(8'h6D);
    @(negedge clk);
    run_frame(8'h6D, 0, 8'h00);

    // Disabled transmitter keeps the byte, overwrite replaces it (R9 R10)
    c_clk = 2'b00; c_pen = 1'b0; c_stop = 2'b01; c_en = 1'b0;
    drive_load(8'h3C);
    repeat (40) @(negedge clk);
    chk(tx_line == 1'b1, "R9 no frame while disabled", tx_line, 1);
    chk(buf_empty == 1'b0, "R9 byte kept while disabled", buf_empty, 0);
    drive_load(8'hC3);
    c_en = 1'b1;
    @(negedge clk);
    chk(tx_line == 1'b0, "R9 start after enable", tx_line, 0);
    run_frame(8'hC3, 0, 8'h00);  // R10: overwritten byte is sent

    // Pausing ticks freezes the start bit (R11)
    c_clk = 2'b01;
    drive_load(8'hA5);
    @(negedge clk);
    repeat (5) @(negedge clk);
    tick_en = 1'b0;
    begin
      bit ok;
      ok = 1;
      for (int k = 0; k < 25; k++) begin
        @(negedge clk);
        if (tx_line != 1'b0) ok = 0;
      end
      chk(ok, "R11 line held without ticks", tx_line, 0);
    end
    tick_en = 1'b1;
    repeat (10) @(negedge clk);
    chk(tx_line == 1'b0, "R11 start resumes remaining ticks", tx_line, 0);
    @(negedge clk);
    chk(tx_line == 1'b1, "R11 first data bit after resume", tx_line, 1);
    repeat (16 * 9 + 20) @(negedge clk);
    chk(tx_line == 1'b1, "R2 idle after paused frame", tx_line, 1);
    chk(buf_empty == 1'b1, "R7 empty after paused frame", buf_empty, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule